// File: doc/BRIEF.md
# Static Memory Strobe Sequencer

This block drives the external strobes for up to three static memory banks: one chip select per bank, a shared write strobe, a shared read (output) enable and per-lane byte selects. An internal requester presents a single-cycle request with the bank, the direction, the byte enables and a flag that marks the access as belonging to the dynamic memory controller. The sequencer then runs the external cycle with the timing programmed for that bank. It pulses `done` for one cycle when the cycle has finished.

Each bank keeps its own strobe length, its own delay from chip select to strobe, its own turnaround count and its own switch that selects a long strobe. The long strobe length is held in one register that all banks share. Idle turnaround cycles are inserted when the data bus changes hands: between a static read and a static write, or between static and dynamic traffic. A dynamic request drives no strobes. It waits out any turnaround and then completes, so that the dynamic controller may take the bus.

Timing writes may arrive at any time. They are staged and reach the live timing only while the sequencer is idle or finishing, so a cycle in progress never changes shape.

Top module: `smc_strobe_seq`

## Requirements
- R1: After reset all outputs are low, the strobe-length field of every bank is 0x1F (a 32-cycle strobe), the turnaround field is 0xF (16 idle cycles), the chip-select-to-strobe delay is 0 and the long-strobe switch is off.
- R2: A static write raises `mem_we` for (strobe field + 1) cycles, with `mem_bls` equal to the request's byte enables over that whole span and `mem_oe` low.
- R3: A static read raises `mem_oe` for (strobe field + 1) cycles, with `mem_we` and `mem_bls` low.
- R4: Only the addressed bank's bit of `mem_cs` rises (bit n for bank n), and it leads the strobe by exactly the bank's delay field, in cycles.
- R5: Chip select stays high for exactly one cycle after the strobe drops, then falls.
- R6: When a static access follows a static access of the other direction, (turnaround field + 1) idle cycles with no chip select precede it. The turnaround field comes from the bank of the new request.
- R7: A change between static and dynamic traffic (`req_dyn` differs from the previous accepted request) inserts the same gap. A dynamic request raises no chip select and no strobe.
- R8: No gap precedes the first request after reset, a static access of the same direction as the previous one, or a dynamic request that follows a dynamic one.
- R9: With a bank's long-strobe switch on (field code 3), that bank's strobe lasts (shared long-strobe register + 1) cycles (field code 4). Other banks are unaffected.
- R10: A timing write made while a cycle is running does not alter that cycle. It applies to the next request.
- R11: `done` is high for exactly one cycle, after chip select has fallen. `busy` is high from the cycle after acceptance through the done cycle. Requests are sampled only while `busy` is low.
- R12: Writing one bank's timing leaves the timing of the other banks unchanged. Field codes: 0 strobe length, 1 chip-select-to-strobe delay, 2 turnaround.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_field | input | 3 | Field code (0 strobe, 1 delay, 2 turnaround, 3 long switch, 4 shared long length) |
| cfg_bank | input | 2 | Bank addressed by the timing write |
| cfg_data | input | 8 | Write data, low bits used per field |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_write | input | 1 | 1 write, 0 read |
| req_dyn | input | 1 | Request belongs to dynamic memory |
| req_bank | input | 2 | Static bank of the request |
| req_be | input | 2 | Byte enables of a write |
| mem_cs | output | 3 | Chip selects, active high, one per bank |
| mem_we | output | 1 | Write strobe, active high |
| mem_oe | output | 1 | Output enable, active high |
| mem_bls | output | 2 | Byte lane selects, active high |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequencer not idle |

## Verification
Two functions can fall in the same cycle here: a timing-register write and a running external cycle that depends on that same register. The bench provokes this by writing a bank's strobe length while that bank's write strobe is high. It then checks that the running strobe keeps the old length and that the next request to the bank uses the new one. A second overlap happens at the done cycle, where staged timing is committed while the sequencer stands ready to accept. The bench issues the next request right after `done` and checks that it sees the committed value.

// File: rtl/smc_seq_pkg.sv
package smc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_TURN   = 3'd1,
      ST_SETUP  = 3'd2,
      ST_STROBE = 3'd3,
      ST_HOLD   = 3'd4,
      ST_DONE   = 3'd5
   } seq_state_t;

   localparam logic [2:0] FLD_STROBE = 3'd0;
   localparam logic [2:0] FLD_DELAY  = 3'd1;
   localparam logic [2:0] FLD_TURN   = 3'd2;
   localparam logic [2:0] FLD_LONGEN = 3'd3;
   localparam logic [2:0] FLD_LONG   = 3'd4;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/smc_bank_regs.sv
module smc_bank_regs
   import smc_seq_pkg::*;
#(
   parameter int NB        = 3,
   parameter int BANK_W    = 2,
   parameter int CFG_W     = 8,
   parameter int LEN_W     = 5,
   parameter int DLY_W     = 4,
   parameter int TURN_W    = 4,
   parameter int LONG_W    = 8,
   parameter bit LONG_EN   = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [2:0]                    cfg_field,
   input  logic [BANK_W-1:0]             cfg_bank,
   input  logic [CFG_W-1:0]              cfg_data,
   input  logic                          commit,
   output logic [NB-1:0][LEN_W-1:0]      len_q,
   output logic [NB-1:0][DLY_W-1:0]      dly_q,
   output logic [NB-1:0][TURN_W-1:0]     turn_q,
   output logic [NB-1:0]                 longen_q,
   output logic [LONG_W-1:0]             long_q
);

   localparam logic [LEN_W-1:0]  LEN_RST  = '1;
   localparam logic [TURN_W-1:0] TURN_RST = '1;
   localparam logic [DLY_W-1:0]  DLY_RST  = '0;
   localparam logic [LONG_W-1:0] LONG_RST = LONG_W'(15);

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic             hit;
      logic [LEN_W-1:0]  stg_len;
      logic [DLY_W-1:0]  stg_dly;
      logic [TURN_W-1:0] stg_turn;

      assign hit = cfg_we && (32'(cfg_bank) == b);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_len  <= LEN_RST;
            stg_dly  <= DLY_RST;
            stg_turn <= TURN_RST;
         end else if (hit) begin
            if (cfg_field == FLD_STROBE) stg_len  <= cfg_data[LEN_W-1:0];
            if (cfg_field == FLD_DELAY)  stg_dly  <= cfg_data[DLY_W-1:0];
            if (cfg_field == FLD_TURN)   stg_turn <= cfg_data[TURN_W-1:0];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            len_q[b]  <= LEN_RST;
            dly_q[b]  <= DLY_RST;
            turn_q[b] <= TURN_RST;
         end else if (commit) begin
            len_q[b]  <= stg_len;
            dly_q[b]  <= stg_dly;
            turn_q[b] <= stg_turn;
         end
      end

      if (LONG_EN) begin : g_long_bit
         logic stg_longen;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                stg_longen <= 1'b0;
            else if (hit && cfg_field == FLD_LONGEN)   stg_longen <= cfg_data[0];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      longen_q[b] <= 1'b0;
            else if (commit) longen_q[b] <= stg_longen;
         end
      end else begin : g_no_long_bit
         assign longen_q[b] = 1'b0;
      end
   end

   if (LONG_EN) begin : g_long_reg
      logic [LONG_W-1:0] stg_long;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               stg_long <= LONG_RST;
         else if (cfg_we && cfg_field == FLD_LONG) stg_long <= cfg_data[LONG_W-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      long_q <= LONG_RST;
         else if (commit) long_q <= stg_long;
      end
   end else begin : g_no_long_reg
      assign long_q = LONG_RST;
   end

endmodule

// File: rtl/smc_turn_gap.sv
module smc_turn_gap (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic req_write,
   input  logic req_dyn,
   output logic need_gap
);

   logic last_vld;
   logic last_wr;
   logic last_dyn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_vld <= 1'b0;
         last_wr  <= 1'b0;
         last_dyn <= 1'b0;
      end else if (accept) begin
         last_vld <= 1'b1;
         last_wr  <= req_write;
         last_dyn <= req_dyn;
      end
   end

   always_comb begin
      need_gap = 1'b0;
      if (last_vld) begin
         if (last_dyn != req_dyn)               need_gap = 1'b1;
         else if (!req_dyn && last_wr != req_write) need_gap = 1'b1;
      end
   end

endmodule

// File: rtl/smc_cycle_fsm.sv
module smc_cycle_fsm
   import smc_seq_pkg::*;
#(
   parameter int NB     = 3,
   parameter int BANK_W = 2,
   parameter int LANES  = 2,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_dyn,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [LANES-1:0]  req_be,
   input  logic              bank_ok,
   input  logic              need_gap,
   input  logic [CNT_W-1:0]  len_sel,
   input  logic [CNT_W-1:0]  dly_sel,
   input  logic [CNT_W-1:0]  turn_sel,
   output logic              accept,
   output logic              commit,
   output logic [NB-1:0]     mem_cs,
   output logic              mem_we,
   output logic              mem_oe,
   output logic [LANES-1:0]  mem_bls,
   output logic              done,
   output logic              busy
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   seq_state_t        st;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  l_len;
   logic [CNT_W-1:0]  l_dly;
   logic [BANK_W-1:0] cur_bank;
   logic              cur_wr;
   logic              cur_dyn;
   logic [LANES-1:0]  cur_be;
   logic              cs_on;

   assign accept = (st == ST_IDLE) && req_valid && bank_ok;
   assign commit = (st == ST_IDLE) || (st == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         l_len    <= '0;
         l_dly    <= '0;
         cur_bank <= '0;
         cur_wr   <= 1'b0;
         cur_dyn  <= 1'b0;
         cur_be   <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (accept) begin
                  l_len    <= len_sel;
                  l_dly    <= dly_sel;
                  cur_bank <= req_bank;
                  cur_wr   <= req_write;
                  cur_dyn  <= req_dyn;
                  cur_be   <= req_be;
                  if (need_gap) begin
                     st  <= ST_TURN;
                     cnt <= turn_sel;
                  end else if (req_dyn) begin
                     st <= ST_DONE;
                  end else if (dly_sel == '0) begin
                     st  <= ST_STROBE;
                     cnt <= len_sel;
                  end else begin
                     st  <= ST_SETUP;
                     cnt <= dly_sel - ONE;
                  end
               end
            end
            ST_TURN: begin
               if (cnt != '0) begin
                  cnt <= cnt - ONE;
               end else if (cur_dyn) begin
                  st <= ST_DONE;
               end else if (l_dly == '0) begin
                  st  <= ST_STROBE;
                  cnt <= l_len;
               end else begin
                  st  <= ST_SETUP;
                  cnt <= l_dly - ONE;
               end
            end
            ST_SETUP: begin
               if (cnt != '0) begin
                  cnt <= cnt - ONE;
               end else begin
                  st  <= ST_STROBE;
                  cnt <= l_len;
               end
            end
            ST_STROBE: begin
               if (cnt != '0) cnt <= cnt - ONE;
               else           st  <= ST_HOLD;
            end
            ST_HOLD: st <= ST_DONE;
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign cs_on = (st == ST_SETUP) || (st == ST_STROBE) || (st == ST_HOLD);

   for (genvar b = 0; b < NB; b++) begin : g_cs
      assign mem_cs[b] = cs_on && (32'(cur_bank) == b);
   end

   assign mem_we  = (st == ST_STROBE) && cur_wr;
   assign mem_oe  = (st == ST_STROBE) && !cur_wr;
   assign mem_bls = ((st == ST_STROBE) && cur_wr) ? cur_be : '0;
   assign done    = (st == ST_DONE);
   assign busy    = (st != ST_IDLE);

endmodule

// File: rtl/smc_strobe_seq.sv
module smc_strobe_seq
   import smc_seq_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int LANES     = 2,
   parameter int CFG_W     = 8,
   parameter int LEN_W     = 5,
   parameter int DLY_W     = 4,
   parameter int TURN_W    = 4,
   parameter int LONG_W    = 8,
   parameter bit LONG_EN   = 1'b1,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [2:0]           cfg_field,
   input  logic [BANK_W-1:0]    cfg_bank,
   input  logic [CFG_W-1:0]     cfg_data,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic                 req_dyn,
   input  logic [BANK_W-1:0]    req_bank,
   input  logic [LANES-1:0]     req_be,
   output logic [NUM_BANKS-1:0] mem_cs,
   output logic                 mem_we,
   output logic                 mem_oe,
   output logic [LANES-1:0]     mem_bls,
   output logic                 done,
   output logic                 busy
);

   localparam int CNT_W = max2(max2(LEN_W, LONG_W), max2(DLY_W, TURN_W));

   if (NUM_BANKS < 1 || NUM_BANKS > 8) begin : g_bad_banks
      $error("NUM_BANKS must lie in 1..8");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (LEN_W > CFG_W || DLY_W > CFG_W || TURN_W > CFG_W || LONG_W > CFG_W) begin : g_bad_w
      $error("timing field wider than cfg_data");
   end
   if (LEN_W < 1 || DLY_W < 1 || TURN_W < 1 || LONG_W < 1) begin : g_zero_w
      $error("timing fields need at least one bit");
   end

   logic [NUM_BANKS-1:0][LEN_W-1:0]  len_q;
   logic [NUM_BANKS-1:0][DLY_W-1:0]  dly_q;
   logic [NUM_BANKS-1:0][TURN_W-1:0] turn_q;
   logic [NUM_BANKS-1:0]             longen_q;
   logic [LONG_W-1:0]                long_q;
   logic                             commit;
   logic                             accept;
   logic                             need_gap;
   logic                             bank_ok;
   logic [BANK_W-1:0]                idx;
   logic [CNT_W-1:0]                 len_sel;
   logic [CNT_W-1:0]                 dly_sel;
   logic [CNT_W-1:0]                 turn_sel;

   smc_bank_regs #(
      .NB(NUM_BANKS), .BANK_W(BANK_W), .CFG_W(CFG_W), .LEN_W(LEN_W),
      .DLY_W(DLY_W), .TURN_W(TURN_W), .LONG_W(LONG_W), .LONG_EN(LONG_EN)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_field(cfg_field),
      .cfg_bank(cfg_bank), .cfg_data(cfg_data), .commit(commit),
      .len_q(len_q), .dly_q(dly_q), .turn_q(turn_q),
      .longen_q(longen_q), .long_q(long_q)
   );

   assign bank_ok = (32'(req_bank) < NUM_BANKS);
   assign idx     = bank_ok ? req_bank : '0;

   always_comb begin
      len_sel  = longen_q[idx] ? CNT_W'(long_q) : CNT_W'(len_q[idx]);
      dly_sel  = CNT_W'(dly_q[idx]);
      turn_sel = CNT_W'(turn_q[idx]);
   end

   smc_turn_gap u_gap (
      .clk(clk), .rst_n(rst_n), .accept(accept),
      .req_write(req_write), .req_dyn(req_dyn), .need_gap(need_gap)
   );

   smc_cycle_fsm #(
      .NB(NUM_BANKS), .BANK_W(BANK_W), .LANES(LANES), .CNT_W(CNT_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_dyn(req_dyn), .req_bank(req_bank), .req_be(req_be),
      .bank_ok(bank_ok), .need_gap(need_gap), .len_sel(len_sel),
      .dly_sel(dly_sel), .turn_sel(turn_sel), .accept(accept),
      .commit(commit), .mem_cs(mem_cs), .mem_we(mem_we), .mem_oe(mem_oe),
      .mem_bls(mem_bls), .done(done), .busy(busy)
   );

endmodule

// File: rtl/smc_seq_chk.sv
module smc_seq_chk #(
   parameter int NUM_BANKS = 3,
   parameter int LANES     = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_BANKS-1:0] mem_cs,
   input logic                 mem_we,
   input logic                 mem_oe,
   input logic [LANES-1:0]     mem_bls,
   input logic                 done,
   input logic                 busy
);

   // R4
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mem_cs));

   // R2
   we_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (|mem_cs));

   // R2
   bls_with_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_bls != '0) |-> mem_we);

   // R3
   oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_oe));

   // R5
   cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(mem_we) || $fell(mem_oe)) |-> (|mem_cs));

   // R5
   cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(mem_we) || $fell(mem_oe)) |=> (mem_cs == '0));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy && mem_cs == '0 && !mem_we && !mem_oe));

endmodule

bind smc_strobe_seq smc_seq_chk #(.NUM_BANKS(NUM_BANKS), .LANES(LANES)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_cs(mem_cs), .mem_we(mem_we),
   .mem_oe(mem_oe), .mem_bls(mem_bls), .done(done), .busy(busy)
);

// File: tb/smc_strobe_seq_test.sv
module smc_strobe_seq_test;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_field = '0;
   logic [1:0] cfg_bank = '0;
   logic [7:0] cfg_data = '0;
   logic       req_valid = 1'b0;
   logic       req_write = 1'b0;
   logic       req_dyn = 1'b0;
   logic [1:0] req_bank = '0;
   logic [1:0] req_be = '0;
   logic [2:0] mem_cs;
   logic       mem_we;
   logic       mem_oe;
   logic [1:0] mem_bls;
   logic       done;
   logic       busy;

   int n_checks = 0;
   int n_fail = 0;

   int m_len [3];
   int m_dly [3];
   int m_turn[3];
   bit m_lon [3];
   int m_long;
   bit l_vld, l_wr, l_dyn;

   always #(CLK_P/2) clk = ~clk;

   smc_strobe_seq uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_field(cfg_field),
      .cfg_bank(cfg_bank), .cfg_data(cfg_data), .req_valid(req_valid),
      .req_write(req_write), .req_dyn(req_dyn), .req_bank(req_bank),
      .req_be(req_be), .mem_cs(mem_cs), .mem_we(mem_we), .mem_oe(mem_oe),
      .mem_bls(mem_bls), .done(done), .busy(busy)
   );

   task automatic check(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cfg_wr(int bank, int field, int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_bank = 2'(bank); cfg_field = 3'(field); cfg_data = 8'(data);
      @(negedge clk);
      cfg_we = 1'b0;
      @(negedge clk);
      case (field)
         0: m_len[bank]  = data;
         1: m_dly[bank]  = data;
         2: m_turn[bank] = data;
         3: m_lon[bank]  = data[0];
         default: m_long = data;
      endcase
   endtask

   // drive one request from a negedge while idle; measures the whole cycle
   task automatic run_access(string gtag, string stag, int bank, bit wr, bit dyn, int be);
      int exp_gap, exp_len, exp_dly, exp_hold;
      int n_gap = 0, n_setup = 0, n_str = 0, n_hold = 0, n_done = 0, n_bad = 0;
      bit fin = 1'b0;
      exp_gap  = (l_vld && (l_dyn != dyn || (!dyn && l_wr != wr))) ? m_turn[bank] + 1 : 0;
      exp_len  = dyn ? 0 : (m_lon[bank] ? m_long + 1 : m_len[bank] + 1);
      exp_dly  = dyn ? 0 : m_dly[bank];
      exp_hold = dyn ? 0 : 1;
      req_valid = 1'b1; req_write = wr; req_dyn = dyn; req_bank = 2'(bank); req_be = 2'(be);
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 4000 && !fin; i++) begin
         if (done) begin
            n_done++;
            if (mem_cs != 0 || mem_we || mem_oe) n_bad++;
            fin = 1'b1;
         end else if (mem_cs == 0) begin
            n_gap++;
            if (mem_we || mem_oe || mem_bls != 0 || !busy) n_bad++;
         end else if (mem_we || mem_oe) begin
            n_str++;
            if (mem_cs != 3'(1 << bank)) n_bad++;
            if (wr && !(mem_we && !mem_oe && mem_bls == 2'(be))) n_bad++;
            if (!wr && !(mem_oe && !mem_we && mem_bls == 0)) n_bad++;
         end else begin
            if (mem_cs != 3'(1 << bank) || mem_bls != 0) n_bad++;
            if (n_str == 0) n_setup++;
            else            n_hold++;
         end
         if (!fin) @(negedge clk);
      end
      if (!fin) begin
         n_fail++; n_checks++;
         $display("FAIL R11 access never finished actual=0 expected=1");
      end
      check(gtag, "gap cycles", n_gap, exp_gap);
      check("R4", "setup cycles", n_setup, exp_dly);
      check(stag, "strobe cycles", n_str, exp_len);
      check("R5", "hold cycles", n_hold, exp_hold);
      check(stag, "strobe/bank errors", n_bad, 0);
      @(negedge clk);
      check("R11", "done then idle", int'(done) + int'(busy), 0);
      l_vld = 1'b1; l_wr = wr; l_dyn = dyn;
   endtask

   task automatic t_reset();
      check("R1", "cs after reset", int'(mem_cs), 0);
      check("R1", "we/oe/bls after reset", int'(mem_we) + int'(mem_oe) + int'(mem_bls), 0);
      check("R11", "done/busy after reset", int'(done) + int'(busy), 0);
   endtask

   task automatic t_defaults();
      // R1 R8: first write, 32-cycle strobe, no gap
      run_access("R8", "R1", 0, 1'b1, 1'b0, 3);
      // R1 R6: read after write, 16-cycle gap
      run_access("R6", "R1", 0, 1'b0, 1'b0, 0);
   endtask

   task automatic t_banks();
      cfg_wr(1, 0, 4); cfg_wr(1, 1, 2); cfg_wr(1, 2, 3);
      // R12: bank 0 still on defaults
      run_access("R8", "R12", 0, 1'b0, 1'b0, 0);
      run_access("R8", "R3", 1, 1'b0, 1'b0, 0);
      cfg_wr(2, 0, 0); cfg_wr(2, 1, 1); cfg_wr(2, 2, 0);
      run_access("R6", "R2", 2, 1'b1, 1'b0, 1);
      run_access("R8", "R2", 1, 1'b1, 1'b0, 2);
   endtask

   task automatic t_dynamic();
      cfg_wr(0, 0, 2); cfg_wr(0, 1, 0); cfg_wr(0, 2, 5);
      run_access("R7", "R7", 0, 1'b0, 1'b1, 0);
      run_access("R8", "R7", 0, 1'b1, 1'b1, 0);
      run_access("R7", "R2", 1, 1'b1, 1'b0, 3);
   endtask

   task automatic t_long();
      cfg_wr(0, 4, 6); cfg_wr(2, 3, 1);
      run_access("R8", "R9", 2, 1'b1, 1'b0, 3);
      run_access("R8", "R9", 1, 1'b1, 1'b0, 1);
      cfg_wr(2, 3, 0);
      run_access("R8", "R9", 2, 1'b1, 1'b0, 2);
   endtask

   task automatic t_write_while_busy();
      fork
         run_access("R8", "R10", 0, 1'b1, 1'b0, 1);
         begin
            repeat (2) @(negedge clk);
            cfg_wr(0, 0, 9);
         end
      join
      run_access("R8", "R10", 0, 1'b1, 1'b0, 2);
   endtask

   initial begin
      #(CLK_P * 200000);
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int b = 0; b < 3; b++) begin
         m_len[b] = 31; m_dly[b] = 0; m_turn[b] = 15; m_lon[b] = 1'b0;
      end
      m_long = 15;
      l_vld = 1'b0; l_wr = 1'b0; l_dyn = 1'b0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_defaults();
      t_banks();
      t_dynamic();
      t_long();
      t_write_while_busy();
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule